// File: doc/BRIEF.md
# Row-Column Separable Transform Sequencer

This block drives a separable two-dimensional transform over a square tile of one colour channel. The tile side is 2**LOG2_DIM samples, and each sample is 16 bits. The default build uses a 32x32 tile. A 128x128 tile is the same block with LOG2_DIM set to 7. The 1D transform arithmetic is not part of the block. It is done by an external streaming engine, reached through a valid/ready input stream and a valid-only output stream.

A start pulse begins a frame. In the row pass, the block pulls samples from a host-filled input FIFO (read latency one cycle) and streams them to the engine in row-major order, with a zero imaginary part. It counts the engine's outputs and stores them in two scratch memories, one for real parts and one for imaginary parts. When every row result has arrived, the column pass starts. It reads the scratch memories in transposed order, so the engine sees column 0 top to bottom, then column 1, and so on. The column results go into two result memories at their natural row*N+col position. A one-cycle done pulse marks the end. A host or a following stage then reads the results through a registered read port.

Top module: `rc2d_sequencer`

## Requirements
- R1: After reset, busy, done, fifo_rd_en and eng_in_valid are 0. A start pulse while idle makes busy 1 from the next cycle. A start pulse while busy has no effect: it causes no extra FIFO reads and no extra done pulse.
- R2: fifo_rd_en is asserted only while fifo_empty is 0. The block treats fifo_rd_data as valid in the cycle after fifo_rd_en. It issues exactly N*N reads per frame.
- R3: In the row pass, engine input sample k (k = row*N+col, counted over accepted handshakes) carries FIFO sample k on eng_in_re, and eng_in_im is 0.
- R4: In the row pass, the k-th engine output sample of the frame is stored at scratch address k, that is row*N+col.
- R5: In the column pass, accepted engine input j carries the stored row result at row j mod N, column j div N, with both its real and imaginary parts. Columns go in increasing order, and rows within a column also go in increasing order.
- R6: In the column pass, the j-th engine output (column j div N, row j mod N) is written to result address row*N+col.
- R7: While eng_in_valid is 1 and eng_in_ready is 0, eng_in_valid stays 1 and eng_in_re and eng_in_im hold their values in the next cycle.
- R8: done is high for exactly one cycle, in the cycle after the last column result is written. busy is 0 in that same cycle.
- R9: res_rd_re and res_rd_im return the result memory contents at res_rd_addr one cycle after the address is presented, with the address laid out as row*N+col.
- R10: Consecutive frames are independent: every counter restarts, and the second frame's results depend only on its own input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame start pulse |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| fifo_empty | input | 1 | Input FIFO has no sample |
| fifo_rd_en | output | 1 | Input FIFO read request |
| fifo_rd_data | input | DW | FIFO sample, valid the cycle after fifo_rd_en |
| eng_in_valid | output | 1 | Engine input sample valid |
| eng_in_ready | input | 1 | Engine accepts the input sample |
| eng_in_re | output | DW | Engine input real part |
| eng_in_im | output | DW | Engine input imaginary part |
| eng_out_valid | input | 1 | Engine output sample valid |
| eng_out_re | input | DW | Engine output real part |
| eng_out_im | input | DW | Engine output imaginary part |
| res_rd_addr | input | 2*LOG2_DIM | Result read address (row*N+col) |
| res_rd_re | output | DW | Result real part, one cycle after address |
| res_rd_im | output | DW | Result imaginary part, one cycle after address |

## Verification
The bench replaces the engine with a fixed-latency loopback. The loopback adds each sample's position within its 1D frame to the real part and adds the real part into the imaginary part, so the final value at every address pins down which sample passed through, in which order, in both passes. A design that read the scratch memory untransposed, or wrote the results transposed, would put the values of mirror-image addresses in the wrong place. A design that lost an element while the engine withheld ready, or while the FIFO ran dry, would shift the whole sequence and change the value the engine sees at every later position. The bench also pulses start in the middle of a frame; a design that restarted on it would issue extra FIFO reads and a second done pulse. Running a second and third frame catches counters that are not cleared between frames.

// File: rtl/rc2d_pkg.sv
package rc2d_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ROW  = 2'd1,
    PH_COL  = 2'd2
  } phase_t;
endpackage

// File: rtl/rc2d_ram.sv
// Simple dual-port memory: one write port, one registered read port.
module rc2d_ram #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rc2d_cplx_ram.sv
// Complex storage built from separate real and imaginary memories.
module rc2d_cplx_ram #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wre,
  input  logic [DW-1:0] wim,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rre,
  output logic [DW-1:0] rim
);
  localparam int LANES = 2;

  logic [LANES-1:0][DW-1:0] wlane;
  logic [LANES-1:0][DW-1:0] rlane;

  assign wlane[0] = wre;
  assign wlane[1] = wim;
  assign rre = rlane[0];
  assign rim = rlane[1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rc2d_ram #(.DW(DW), .AW(AW)) u_ram (
      .clk  (clk),
      .we   (we),
      .waddr(waddr),
      .wdata(wlane[g]),
      .raddr(raddr),
      .rdata(rlane[g])
    );
  end
endmodule

// File: rtl/rc2d_walk.sv
// Tile position counter. Count c*N+r maps to address r*N+c when tr is set.
module rc2d_walk #(
  parameter int L = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           step,
  input  logic           tr,
  output logic [2*L-1:0] addr,
  output logic           last
);
  localparam int AW = 2 * L;

  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign last = &cnt;
  assign addr = tr ? {cnt[L-1:0], cnt[AW-1:L]} : cnt;
endmodule

// File: rtl/rc2d_skid.sv
// Two-entry buffer between the one-cycle-latency sources and the engine input.
module rc2d_skid #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] pdata,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] head,
  output logic [1:0]   level
);
  logic [W-1:0] e0, e1;
  logic [1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= 2'd0;
    end else begin
      unique case ({push, pop})
        2'b10: begin
          if (cnt == 2'd0) e0 <= pdata;
          else             e1 <= pdata;
          cnt <= cnt + 2'd1;
        end
        2'b01: begin
          e0  <= e1;
          cnt <= cnt - 2'd1;
        end
        2'b11: begin
          if (cnt == 2'd1) begin
            e0 <= pdata;
          end else begin
            e0 <= e1;
            e1 <= pdata;
          end
        end
        default: ;
      endcase
    end
  end

  assign valid = (cnt != 2'd0);
  assign head  = e0;
  assign level = cnt;

  AST_SKID_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (cnt != 2'd2)); // R7
  AST_SKID_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt != 2'd0)); // R7
endmodule

// File: rtl/rc2d_sequencer.sv
module rc2d_sequencer #(
  parameter int LOG2_DIM = 5,
  parameter int DW       = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  input  logic                  fifo_empty,
  output logic                  fifo_rd_en,
  input  logic [DW-1:0]         fifo_rd_data,
  output logic                  eng_in_valid,
  input  logic                  eng_in_ready,
  output logic [DW-1:0]         eng_in_re,
  output logic [DW-1:0]         eng_in_im,
  input  logic                  eng_out_valid,
  input  logic [DW-1:0]         eng_out_re,
  input  logic [DW-1:0]         eng_out_im,
  input  logic [2*LOG2_DIM-1:0] res_rd_addr,
  output logic [DW-1:0]         res_rd_re,
  output logic [DW-1:0]         res_rd_im
);
  import rc2d_pkg::*;

  localparam int AW = 2 * LOG2_DIM;
  localparam int SW = 2 * DW;

  phase_t        phase;
  logic          is_row, is_col;
  logic          pass_clr, row_end, col_end;
  logic          issue, issue_done, pend, room, pop;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          rd_last, wr_last;
  logic [1:0]    skid_level;
  logic [2:0]    occ;
  logic [SW-1:0] push_data, skid_head;
  logic [DW-1:0] tmp_re, tmp_im;
  logic          out_fire;

  assign is_row   = (phase == PH_ROW);
  assign is_col   = (phase == PH_COL);
  assign busy     = (phase != PH_IDLE);
  assign out_fire = busy && eng_out_valid;
  assign row_end  = is_row && eng_out_valid && wr_last;
  assign col_end  = is_col && eng_out_valid && wr_last;
  assign pass_clr = ((phase == PH_IDLE) && start) || row_end;

  // Pass sequencing: the pass changes on the output count, not the input count.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      done <= col_end;
      unique case (phase)
        PH_IDLE: if (start)   phase <= PH_ROW;
        PH_ROW:  if (row_end) phase <= PH_COL;
        PH_COL:  if (col_end) phase <= PH_IDLE;
        default:              phase <= PH_IDLE;
      endcase
    end
  end

  // Source read issue, with credit for the skid buffer.
  assign pop  = eng_in_valid && eng_in_ready;
  assign occ  = {1'b0, skid_level} + {2'b00, pend};
  assign room = (occ - {2'b00, pop}) < 3'd2;
  assign issue = busy && !issue_done && room && (is_col || !fifo_empty);
  assign fifo_rd_en = issue && is_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 1'b0;
      issue_done <= 1'b0;
    end else begin
      pend <= issue;
      if (pass_clr)             issue_done <= 1'b0;
      else if (issue && rd_last) issue_done <= 1'b1;
    end
  end

  rc2d_walk #(.L(LOG2_DIM)) u_rd_walk (
    .clk (clk),
    .rst (rst),
    .clr (pass_clr),
    .step(issue),
    .tr  (is_col),
    .addr(rd_addr),
    .last(rd_last)
  );

  rc2d_walk #(.L(LOG2_DIM)) u_wr_walk (
    .clk (clk),
    .rst (rst),
    .clr (pass_clr),
    .step(out_fire),
    .tr  (is_col),
    .addr(wr_addr),
    .last(wr_last)
  );

  assign push_data = is_col ? {tmp_re, tmp_im} : {fifo_rd_data, {DW{1'b0}}};

  rc2d_skid #(.W(SW)) u_skid (
    .clk  (clk),
    .rst  (rst),
    .push (pend),
    .pdata(push_data),
    .pop  (pop),
    .valid(eng_in_valid),
    .head (skid_head),
    .level(skid_level)
  );

  assign eng_in_re = skid_head[SW-1:DW];
  assign eng_in_im = skid_head[DW-1:0];

  rc2d_cplx_ram #(.DW(DW), .AW(AW)) u_tmp (
    .clk  (clk),
    .we   (is_row && eng_out_valid),
    .waddr(wr_addr),
    .wre  (eng_out_re),
    .wim  (eng_out_im),
    .raddr(rd_addr),
    .rre  (tmp_re),
    .rim  (tmp_im)
  );

  rc2d_cplx_ram #(.DW(DW), .AW(AW)) u_res (
    .clk  (clk),
    .we   (is_col && eng_out_valid),
    .waddr(wr_addr),
    .wre  (eng_out_re),
    .wim  (eng_out_im),
    .raddr(res_rd_addr),
    .rre  (res_rd_re),
    .rim  (res_rd_im)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!fifo_rd_en && !eng_in_valid)); // R1
  AST_FIFO_RD_GUARD: assert property (@(posedge clk) disable iff (rst)
    fifo_rd_en |-> !fifo_empty); // R2
  AST_ROW_IM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (is_row && eng_in_valid) |-> (eng_in_im == '0)); // R3
  AST_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (eng_in_valid && !eng_in_ready) |=> (eng_in_valid && $stable(eng_in_re) && $stable(eng_in_im))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8
endmodule

// File: tb/rc2d_sequencer_bench.sv
module rc2d_sequencer_bench;
  localparam int L  = 3;
  localparam int N  = 1 << L;
  localparam int NN = N * N;
  localparam int DW = 16;
  localparam int AW = 2 * L;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          busy, done;
  logic          fifo_empty, fifo_rd_en;
  logic [DW-1:0] fifo_rd_data;
  logic          eng_in_valid, eng_in_ready;
  logic [DW-1:0] eng_in_re, eng_in_im;
  logic          eng_out_valid;
  logic [DW-1:0] eng_out_re, eng_out_im;
  logic [AW-1:0] res_rd_addr = '0;
  logic [DW-1:0] res_rd_re, res_rd_im;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rc2d_sequencer #(.LOG2_DIM(L), .DW(DW)) u_rc2d_sequencer (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .fifo_empty(fifo_empty), .fifo_rd_en(fifo_rd_en), .fifo_rd_data(fifo_rd_data),
    .eng_in_valid(eng_in_valid), .eng_in_ready(eng_in_ready),
    .eng_in_re(eng_in_re), .eng_in_im(eng_in_im),
    .eng_out_valid(eng_out_valid), .eng_out_re(eng_out_re), .eng_out_im(eng_out_im),
    .res_rd_addr(res_rd_addr), .res_rd_re(res_rd_re), .res_rd_im(res_rd_im)
  );

  function automatic logic [DW-1:0] pix(int f, int r, int c);
    return 16'(f * 97 + r * 13 + c * 7 + r * c * 3 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pattern source for backpressure and FIFO gaps.
  logic [7:0] lf;
  bit bp_mode = 1'b0;
  bit stall_mode = 1'b0;
  always @(posedge clk) begin
    if (rst) lf <= 8'h5B;
    else     lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
  end
  assign eng_in_ready = !bp_mode || lf[0];

  // Input FIFO model: sample k of the stream is frame k/NN, position k%NN.
  int fifo_ptr = 0;
  int fifo_limit = 0;
  assign fifo_empty = (fifo_ptr >= fifo_limit) || (stall_mode && lf[3]);
  always @(posedge clk) begin
    if (fifo_rd_en) begin
      fifo_rd_data <= pix(fifo_ptr / NN, (fifo_ptr % NN) / N, fifo_ptr % N);
      fifo_ptr     <= fifo_ptr + 1;
    end
  end

  // Loopback engine, latency 3: re += position in 1D frame, im += re.
  logic          pv0, pv1, pv2;
  logic [DW-1:0] pr0, pr1, pr2, pi0, pi1, pi2;
  int            kpos;
  always @(posedge clk) begin
    if (rst) begin
      pv0 <= 1'b0; pv1 <= 1'b0; pv2 <= 1'b0; kpos <= 0;
    end else begin
      pv0 <= eng_in_valid && eng_in_ready;
      pr0 <= eng_in_re + 16'(kpos);
      pi0 <= eng_in_im + eng_in_re;
      pv1 <= pv0; pr1 <= pr0; pi1 <= pi0;
      pv2 <= pv1; pr2 <= pr1; pi2 <= pi1;
      if (eng_in_valid && eng_in_ready) kpos <= (kpos + 1) % N;
    end
  end
  assign eng_out_valid = pv2;
  assign eng_out_re    = pr2;
  assign eng_out_im    = pi2;

  // Engine-input monitor, sampled away from the active edge.
  int in_idx = 0;
  int done_cnt = 0;
  int mon_frame = 0;
  bit prev_stall = 1'b0;
  bit prev_done = 1'b0;
  logic [DW-1:0] prev_re, prev_im;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall)
        chk(eng_in_valid && eng_in_re == prev_re && eng_in_im == prev_im,
            "R7 hold", int'(eng_in_re), int'(prev_re));
      if (eng_in_valid && eng_in_ready) begin
        if (in_idx < NN) begin
          chk(eng_in_re == pix(mon_frame, in_idx / N, in_idx % N), "R3 row re",
              int'(eng_in_re), int'(pix(mon_frame, in_idx / N, in_idx % N)));
          chk(eng_in_im == 16'd0, "R3 row im", int'(eng_in_im), 0);
        end else begin
          automatic int j = in_idx - NN;
          automatic int c = j / N;
          automatic int r = j % N;
          automatic logic [DW-1:0] p = pix(mon_frame, r, c);
          chk(eng_in_re == 16'(p + 16'(c)), "R5 col re", int'(eng_in_re), int'(16'(p + 16'(c))));
          chk(eng_in_im == p, "R4 R5 col im", int'(eng_in_im), int'(p));
        end
        in_idx++;
        if (in_idx == 2 * NN) begin
          in_idx = 0;
          mon_frame++;
        end
      end
      if (done) begin
        done_cnt++;
        chk(!busy, "R8 busy low with done", int'(busy), 0);
        chk(!prev_done, "R8 single pulse", int'(prev_done), 0);
      end
      prev_done  = done;
      prev_stall = eng_in_valid && !eng_in_ready;
      prev_re    = eng_in_re;
      prev_im    = eng_in_im;
    end
  end

  task automatic run_frame(input int f, input bit bp, input bit stl, input bit mid_start);
    int waited;
    int target;
    bp_mode    = bp;
    stall_mode = stl;
    fifo_limit = (f + 1) * NN;
    target     = done_cnt + 1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R1 busy after start", int'(busy), 1);
    waited = 0;
    while (done_cnt < target && waited < 20000) begin
      @(negedge clk);
      waited++;
      if (mid_start && waited == 40) start = 1'b1;
      if (mid_start && waited == 41) start = 1'b0;
    end
    chk(waited < 20000, "R8 done reached", waited, 0);
    repeat (20) @(negedge clk);
    chk(done_cnt == target, "R1 R8 done count", done_cnt, target);
    chk(fifo_ptr == (f + 1) * NN, "R2 read count", fifo_ptr, (f + 1) * NN);
    chk(!busy, "R1 idle after frame", int'(busy), 0);
    for (int a = 0; a < NN; a++) begin
      automatic int r = a / N;
      automatic int c = a % N;
      automatic logic [DW-1:0] p = pix(f, r, c);
      automatic logic [DW-1:0] er = 16'(p + 16'(c) + 16'(r));
      automatic logic [DW-1:0] ei = 16'(p + p + 16'(c));
      res_rd_addr = AW'(a);
      @(negedge clk);
      chk(res_rd_re == er, "R6 R9 R10 result re", int'(res_rd_re), int'(er));
      chk(res_rd_im == ei, "R6 R9 R10 result im", int'(res_rd_im), int'(ei));
    end
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R1 reset busy/done", int'(busy), 0);
    chk(!fifo_rd_en && !eng_in_valid, "R1 reset quiet", int'(eng_in_valid), 0);
    run_frame(0, 1'b0, 1'b0, 1'b0);
    run_frame(1, 1'b1, 1'b1, 1'b0);
    run_frame(2, 1'b1, 1'b0, 1'b1);
    run_frame(3, 1'b0, 1'b1, 1'b0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule